// File: doc/BRIEF.md
# DDR Read-to-Write Turnaround Sequencer

This block sits in the command path of a DDR SDRAM controller. It issues reads to rows that are already open. When a write request arrives while one of those reads is still returning data, the block works out how to end the read and how soon the write may follow. It compares the write's bank and row with the read in flight and with a per-bank table of open rows. From that comparison it takes one of two routes. The first is a burst stop followed by the write after the bus turnaround interval. The second precharges the target bank, opens the requested row, and then writes after the activate-to-write delay.

Exactly one command leaves the block per clock. Every cycle with nothing legal to issue carries NOP. All intervals are parameters counted in clock cycles: turnaround after burst stop, precharge-to-activate, and activate-to-write. An elaboration check rejects a burst-stop turnaround shorter than the CAS latency. The requester holds its write request and target stable until `wr_ready` pulses, which happens in the same cycle the write command is driven.

Top module: `rtt_turnaround`

## Requirements
- R1: While and after reset, `cmd` is NOP, `wr_ready` is low and every bank is treated as idle, so a read request is dropped until a row has been opened.
- R2: Command codes on `cmd` are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, BST=5. A read request with no write pending, to a bank whose open row equals `rd_row`, yields READ one cycle later. A read to an idle bank or to a different row yields no command.
- R3: A write to the same bank and row as a read in flight yields BST on the cycle after acceptance, then WRITE exactly T_BSTW cycles after the BST.
- R4: A write to the read's bank but another row yields PRE of that bank, then ACT of the new row exactly T_RP cycles after the PRE, then WRITE exactly T_RCD cycles after the ACT.
- R5: A write to another bank whose open row matches, while a read is in flight, yields BST and then WRITE exactly T_BSTW cycles later.
- R6: A write to an idle bank yields ACT with no burst stop. WRITE follows at the later of T_RCD cycles after the ACT and CAS_LAT + BURST_LEN/2 cycles after the READ in flight (if any).
- R7: A write to a bank that has a different row open, other than the bank being read, yields PRE of that bank, ACT T_RP later, and WRITE no earlier than T_RCD after the ACT or the read's end. The read is not stopped.
- R8: With no read in flight and the target row open, the only command issued for the write is WRITE.
- R9: `wr_ready` is high in exactly the cycles where `cmd` is WRITE. WRITE carries the requested bank on `cmd_bank`, and ACT carries the requested row on `cmd_addr`.
- R10: When read and write requests arrive together in an idle cycle, the write is served and no READ is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, one cycle |
| rd_bank | input | BANK_W | Read target bank |
| rd_row | input | ROW_W | Read target row (must be open) |
| wr_req | input | 1 | Write request, held until `wr_ready` |
| wr_bank | input | BANK_W | Write target bank |
| wr_row | input | ROW_W | Write target row |
| cmd | output | 3 | DDR command code (see R2) |
| cmd_bank | output | BANK_W | Bank the command addresses |
| cmd_addr | output | ROW_W | Row for ACT; row tag for READ/WRITE |
| wr_ready | output | 1 | Pulses in the cycle WRITE is driven |

## Verification
The bench walks a chain of writes whose outcome depends on bank state left by the previous ones. It measures the exact cycle distance between every pair of commands on each route. A sequencer that confused "same bank, other row" with "same row" would issue BST where PRE belongs and write into the wrong row. One that ignored the read-data tail would place WRITE too early on the idle-bank route, where the bus interval rather than T_RCD sets the gap. Dropped reads to closed rows after reset and write priority over a simultaneous read are probed at the command port. A design that kept stale open-row state, or let the read win the collision, would emit a READ there.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_BST   = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE_WAIT,
        ST_WR_WAIT,
        ST_DONE
    } st_e;

endpackage

// File: rtl/rtt_countdown.sv
module rtt_countdown #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R6: an interval shrinks by one per cycle, never skips
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rtt_bank_table.sv
module rtt_bank_table import rtt_pkg::*; #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  cmd_e                             cmd_i,
    input  logic [BANK_W-1:0]                bank_i,
    input  logic [ROW_W-1:0]                 row_i,
    output logic [NUM_BANKS-1:0]             open_o,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]  row_o
);
    logic [NUM_BANKS-1:0]            open_d, open_q;
    logic [NUM_BANKS-1:0][ROW_W-1:0] row_d, row_q;

    always_comb begin
        open_d = open_q;
        row_d  = row_q;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_i == BANK_W'(i)) begin
                if (cmd_i == CMD_ACT) begin
                    open_d[i] = 1'b1;
                    row_d[i]  = row_i;
                end else if (cmd_i == CMD_PRE) begin
                    open_d[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= '0;
            row_q  <= '0;
        end else begin
            open_q <= open_d;
            row_q  <= row_d;
        end
    end

    assign open_o = open_q;
    assign row_o  = row_q;

    // R2: a read only ever goes to the row that is open in its bank
    a_r2_read_hits_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_READ) |-> (open_q[bank_i] && row_q[bank_i] == row_i));

    // R6: activate only an idle bank
    a_r6_act_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT) |-> !open_q[bank_i]);

    // R7: precharge only a bank that is open
    a_r7_pre_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE) |-> open_q[bank_i]);

endmodule

// File: rtl/rtt_turnaround.sv
module rtt_turnaround import rtt_pkg::*; #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    parameter int T_BSTW    = 4,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              wr_req,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              wr_ready
);
    localparam int RD_SPAN = CAS_LAT + BURST_LEN / 2;
    localparam int MAX_A   = (RD_SPAN > T_BSTW) ? RD_SPAN : T_BSTW;
    localparam int MAX_B   = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int MAX_T   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_T + 1);

    generate
        if (T_BSTW < CAS_LAT) begin : g_bad_bstw
            $error("T_BSTW must not be shorter than CAS_LAT");
        end
        if (T_BSTW < 1 || T_RP < 1 || T_RCD < 1) begin : g_bad_zero
            $error("timing parameters must be at least one cycle");
        end
    endgenerate

    typedef struct packed {
        st_e               st;
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  addr;
        logic              ready;
        logic [BANK_W-1:0] tbank;
        logic [ROW_W-1:0]  trow;
        logic              rd_live;
        logic [BANK_W-1:0] rbank;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             wait_ld, tat_ld;
    logic [CNT_W-1:0] wait_val, tat_val;
    logic             wait_zero, tat_zero;

    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic wr_hit, rd_hit;

    assign wr_hit = bank_open[wr_bank] && (bank_row[wr_bank] == wr_row);
    assign rd_hit = bank_open[rd_bank] && (bank_row[rd_bank] == rd_row);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.cmd   = CMD_NOP;
        ctl_d.ready = 1'b0;
        wait_ld     = 1'b0;
        wait_val    = '0;
        tat_ld      = 1'b0;
        tat_val     = '0;
        if (ctl_q.rd_live && tat_zero)
            ctl_d.rd_live = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (wr_req) begin
                    ctl_d.tbank = wr_bank;
                    ctl_d.trow  = wr_row;
                    if (wr_hit) begin
                        if (ctl_q.rd_live) begin
                            ctl_d.cmd     = CMD_BST;
                            ctl_d.bank    = ctl_q.rbank;
                            tat_ld        = 1'b1;
                            tat_val       = CNT_W'(T_BSTW - 1);
                            ctl_d.rd_live = 1'b0;
                        end
                        wait_ld  = 1'b1;
                        ctl_d.st = ST_WR_WAIT;
                    end else if (bank_open[wr_bank]) begin
                        ctl_d.cmd  = CMD_PRE;
                        ctl_d.bank = wr_bank;
                        wait_ld    = 1'b1;
                        wait_val   = CNT_W'(T_RP - 1);
                        ctl_d.st   = ST_PRE_WAIT;
                        if (ctl_q.rd_live && ctl_q.rbank == wr_bank) begin
                            tat_ld        = 1'b1;
                            tat_val       = CNT_W'(T_BSTW - 1);
                            ctl_d.rd_live = 1'b0;
                        end
                    end else begin
                        ctl_d.cmd  = CMD_ACT;
                        ctl_d.bank = wr_bank;
                        ctl_d.addr = wr_row;
                        wait_ld    = 1'b1;
                        wait_val   = CNT_W'(T_RCD - 1);
                        ctl_d.st   = ST_WR_WAIT;
                    end
                end else if (rd_req && rd_hit) begin
                    ctl_d.cmd     = CMD_READ;
                    ctl_d.bank    = rd_bank;
                    ctl_d.addr    = rd_row;
                    ctl_d.rd_live = 1'b1;
                    ctl_d.rbank   = rd_bank;
                    tat_ld        = 1'b1;
                    tat_val       = CNT_W'(RD_SPAN - 1);
                end
            end
            ST_PRE_WAIT: begin
                if (wait_zero) begin
                    ctl_d.cmd  = CMD_ACT;
                    ctl_d.bank = ctl_q.tbank;
                    ctl_d.addr = ctl_q.trow;
                    wait_ld    = 1'b1;
                    wait_val   = CNT_W'(T_RCD - 1);
                    ctl_d.st   = ST_WR_WAIT;
                end
            end
            ST_WR_WAIT: begin
                if (wait_zero && tat_zero) begin
                    ctl_d.cmd   = CMD_WRITE;
                    ctl_d.bank  = ctl_q.tbank;
                    ctl_d.addr  = ctl_q.trow;
                    ctl_d.ready = 1'b1;
                    ctl_d.st    = ST_DONE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rtt_countdown #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load_i(wait_ld), .load_val_i(wait_val), .zero_o(wait_zero)
    );

    rtt_countdown #(.CNT_W(CNT_W)) u_tat (
        .clk(clk), .rst_n(rst_n), .load_i(tat_ld), .load_val_i(tat_val), .zero_o(tat_zero)
    );

    rtt_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_banks (
        .clk(clk), .rst_n(rst_n), .cmd_i(ctl_d.cmd), .bank_i(ctl_d.bank), .row_i(ctl_d.addr),
        .open_o(bank_open), .row_o(bank_row)
    );

    assign cmd      = ctl_q.cmd;
    assign cmd_bank = ctl_q.bank;
    assign cmd_addr = ctl_q.addr;
    assign wr_ready = ctl_q.ready;

    // R9: handshake coincides with the write command
    a_r9_ready_marks_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (cmd == CMD_WRITE));

    // R9: handshake is a single-cycle pulse
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |=> !wr_ready);

    // R3: the cycle after a burst stop carries NOP unless the interval is one
    a_r3_bst_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST) |=> (T_BSTW == 1 || cmd == CMD_NOP));

    // R10: a colliding read never wins
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && wr_req && rd_req) |=> (cmd != CMD_READ));

endmodule

// File: tb/tb_rtt_turnaround.sv
`timescale 1ns/1ps
module tb_rtt_turnaround;
    localparam int CL     = 3;
    localparam int BL     = 4;
    localparam int TBSTW  = 4;
    localparam int TRP    = 3;
    localparam int TRCD   = 3;
    localparam int SPAN   = CL + BL / 2;
    localparam int G_IDLE = (TRCD > SPAN - 1) ? TRCD : SPAN - 1;
    localparam int G_OTH  = (TRCD > SPAN - 1 - TRP) ? TRCD : SPAN - 1 - TRP;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR = 3'd3, C_PRE = 3'd4, C_BST = 3'd5;

    typedef struct packed {
        logic        rd;
        logic [1:0]  rb;
        logic [12:0] rr;
        logic [1:0]  wb;
        logic [12:0] wr;
        logic [2:0]  n;
        logic [2:0]  c0, c1, c2, c3;
        logic [3:0]  g0, g1, g2;
    } vec_t;

    localparam vec_t TAB [0:7] = '{
        '{1'b0, 2'd0, 13'd0, 2'd0, 13'd5, 3'd2, C_ACT, C_WR,  C_NOP, C_NOP, 4'(TRCD), 4'd0, 4'd0},
        '{1'b1, 2'd0, 13'd5, 2'd0, 13'd5, 3'd3, C_RD,  C_BST, C_WR,  C_NOP, 4'd1, 4'(TBSTW), 4'd0},
        '{1'b1, 2'd0, 13'd5, 2'd0, 13'd9, 3'd4, C_RD,  C_PRE, C_ACT, C_WR,  4'd1, 4'(TRP), 4'(TRCD)},
        '{1'b1, 2'd0, 13'd9, 2'd1, 13'd7, 3'd3, C_RD,  C_ACT, C_WR,  C_NOP, 4'd1, 4'(G_IDLE), 4'd0},
        '{1'b1, 2'd0, 13'd9, 2'd1, 13'd7, 3'd3, C_RD,  C_BST, C_WR,  C_NOP, 4'd1, 4'(TBSTW), 4'd0},
        '{1'b1, 2'd0, 13'd9, 2'd1, 13'd2, 3'd4, C_RD,  C_PRE, C_ACT, C_WR,  4'd1, 4'(TRP), 4'(G_OTH)},
        '{1'b0, 2'd0, 13'd0, 2'd1, 13'd2, 3'd1, C_WR,  C_NOP, C_NOP, C_NOP, 4'd0, 4'd0, 4'd0},
        '{1'b0, 2'd0, 13'd0, 2'd0, 13'd1, 3'd3, C_PRE, C_ACT, C_WR,  C_NOP, 4'(TRP), 4'(TRCD), 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_req, wr_req;
    logic [1:0]  rd_bank, wr_bank;
    logic [12:0] rd_row, wr_row;
    logic [2:0]  cmd;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        wr_ready;

    rtt_turnaround #(
        .NUM_BANKS(4), .ROW_W(13), .CAS_LAT(CL), .BURST_LEN(BL),
        .T_BSTW(TBSTW), .T_RP(TRP), .T_RCD(TRCD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_bank(rd_bank), .rd_row(rd_row),
        .wr_req(wr_req), .wr_bank(wr_bank), .wr_row(wr_row), .cmd(cmd),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .wr_ready(wr_ready)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int ln  = 0;
    logic [2:0]  lc [0:255];
    int          lt [0:255];
    logic [1:0]  lb [0:255];
    logic [12:0] la [0:255];
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n && cmd != C_NOP && ln < 256) begin
            lc[ln] = cmd; lt[ln] = cyc; lb[ln] = cmd_bank; la[ln] = cmd_addr;
            ln++;
        end
        if (rst_n && (wr_ready || cmd == C_WR))
            chk(wr_ready == (cmd == C_WR), "R9 ready/write alignment", int'(wr_ready), int'(cmd == C_WR));
    end

    function automatic string vtag(input int i);
        case (i)
            1: return "R3 same bank same row";
            2: return "R4 same bank other row";
            3: return "R6 idle bank during read";
            4: return "R5 other bank open row";
            5: return "R7 other bank other row";
            6: return "R8 open row no read";
            7: return "R7 other row no read";
            default: return "R6 idle bank";
        endcase
    endfunction

    function automatic logic [2:0] vcmd(input vec_t v, input int k);
        case (k)
            0: return v.c0;
            1: return v.c1;
            2: return v.c2;
            default: return v.c3;
        endcase
    endfunction

    function automatic int vgap(input vec_t v, input int k);
        case (k)
            0: return int'(v.g0);
            1: return int'(v.g1);
            default: return int'(v.g2);
        endcase
    endfunction

    task automatic wait_ready();
        int g = 0;
        while (!wr_ready && g < 60) begin
            @(negedge clk);
            g++;
        end
        chk(g < 60, "R9 wr_ready arrives", g, 0);
        wr_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input int i);
        vec_t v = TAB[i];
        int base = ln;
        int n;
        @(negedge clk);
        if (v.rd) begin
            rd_req = 1'b1; rd_bank = v.rb; rd_row = v.rr;
            @(negedge clk);
            rd_req = 1'b0;
        end
        wr_req = 1'b1; wr_bank = v.wb; wr_row = v.wr;
        wait_ready();
        n = ln - base;
        chk(n == int'(v.n), {vtag(i), " command count"}, n, int'(v.n));
        if (n == int'(v.n)) begin
            for (int k = 0; k < n; k++) begin
                chk(lc[base+k] == vcmd(v, k), {vtag(i), " command"}, int'(lc[base+k]), int'(vcmd(v, k)));
                if (k > 0)
                    chk(lt[base+k] - lt[base+k-1] == vgap(v, k-1), {vtag(i), " spacing"},
                        lt[base+k] - lt[base+k-1], vgap(v, k-1));
                if (lc[base+k] == C_ACT)
                    chk(la[base+k] == v.wr, "R9 activate row", int'(la[base+k]), int'(v.wr));
                if (lc[base+k] == C_PRE || lc[base+k] == C_WR)
                    chk(lb[base+k] == v.wb, "R9 target bank", int'(lb[base+k]), int'(v.wb));
            end
        end
        repeat (SPAN + 2) @(negedge clk);
    endtask

    task automatic dropped_read(input logic [1:0] b, input logic [12:0] r, input string tag);
        int base;
        @(negedge clk);
        base = ln;
        rd_req = 1'b1; rd_bank = b; rd_row = r;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(ln == base, tag, ln - base, 0);
    endtask

    initial begin
        rst_n = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
        rd_bank = '0; rd_row = '0; wr_bank = '0; wr_row = '0;
        repeat (3) @(negedge clk);
        chk(cmd == C_NOP, "R1 cmd NOP in reset", int'(cmd), 0);
        chk(!wr_ready, "R1 ready low in reset", int'(wr_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd == C_NOP, "R1 cmd NOP after reset", int'(cmd), 0);

        // R2 / R1: no row open yet, read is dropped
        dropped_read(2'd0, 13'd5, "R2 read to idle bank dropped");

        for (int i = 0; i < 8; i++) run_vec(i);

        // R2: read to open row (bank0 row1) appears one cycle later
        begin
            int base, t0;
            @(negedge clk);
            base = ln; t0 = cyc;
            rd_req = 1'b1; rd_bank = 2'd0; rd_row = 13'd1;
            @(negedge clk);
            rd_req = 1'b0;
            @(negedge clk);
            chk(ln - base == 1, "R2 read issued once", ln - base, 1);
            chk(lc[base] == C_RD, "R2 read code", int'(lc[base]), int'(C_RD));
            chk(lt[base] - t0 == 1, "R2 read latency", lt[base] - t0, 1);
            chk(la[base] == 13'd1, "R2 read row tag", int'(la[base]), 1);
            repeat (SPAN + 2) @(negedge clk);
        end

        // R2: read to open bank but other row is dropped
        dropped_read(2'd1, 13'd3, "R2 read to other row dropped");

        // R10: simultaneous read and write, write wins
        begin
            int base;
            @(negedge clk);
            base = ln;
            rd_req = 1'b1; rd_bank = 2'd0; rd_row = 13'd1;
            wr_req = 1'b1; wr_bank = 2'd1; wr_row = 13'd2;
            @(negedge clk);
            rd_req = 1'b0;
            wait_ready();
            chk(ln - base == 1, "R10 single command", ln - base, 1);
            chk(lc[base] == C_WR, "R10 write served", int'(lc[base]), int'(C_WR));
        end

        // R1: reset clears the bank table
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cmd == C_NOP && !wr_ready, "R1 outputs quiet in reset", int'(cmd), 0);
        rst_n = 1'b1;
        dropped_read(2'd0, 13'd1, "R1 banks idle after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule